// File: doc/BRIEF.md
# Timer Clock-Select Prescaler

This block produces the count-enable tick that advances a timer counter. A 3-bit select code picks the tick source: nothing (timer halted), every system clock, one of four fixed divisions of the system clock, or an active edge of an external pin. The edge on the pin is chosen by the code. The counter that consumes the tick is outside this block.

A free-running 10-bit prescale counter starts from zero at reset and advances on every system clock. Each divided rate is tapped from its low bits. The external pin first passes through a two-flop synchronizer. A rising or falling edge is then detected in the system clock domain. The selected source is registered, so `tick_o` is a clean one-cycle pulse that the timer can use directly as a clock enable.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_ni` is low, and until the first rising clock edge after its release, `tick_o` is 0.
- R2: With `sel_i` = 3'b000, `tick_o` stays 0 whatever `ext_i` does.
- R3: With `sel_i` = 3'b001, `tick_o` is 1 after every clock edge.
- R4: With `sel_i` = 3'b010, 3'b011, 3'b100 or 3'b101, `tick_o` is 1 for one cycle after edge number e (edges counted from reset release, the first being 1) exactly when e is a multiple of 8, 64, 256 or 1024 respectively.
- R5: The prescale counter is never cleared by a change of `sel_i`. After a switch, the divided ticks keep the phase counted from reset release.
- R6: With `sel_i` = 3'b111, a low-to-high change of `ext_i` made between edges sets `tick_o` to 1 for exactly one cycle after the third following clock edge.
- R7: With `sel_i` = 3'b110, a high-to-low change of `ext_i` sets `tick_o` to 1 for exactly one cycle after the third following clock edge.
- R8: With `sel_i` = 3'b111, falling changes of `ext_i` produce no tick. With 3'b110, rising changes produce none.
- R9: When `ext_i` toggles every two cycles, each active edge yields its own one-cycle tick and no pulses merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Tick source select code |
| ext_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The hardest situation to reach is the phase of the divided ticks after a mid-run change of the select code. It is only visible if the stimulus knows how many edges have passed since reset. The bench therefore keeps its own edge count from reset release. It runs the slowest ratio for an odd number of cycles, switches to a faster one, and checks each tick against that count. Pin edge tests place each transition at a falling clock edge, so the three-edge latency is exact. They then sweep a window around it, which also shows that each pulse lasts only one cycle.

// File: rtl/timer_tick_pkg.sv
package timer_tick_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'b000,
    SEL_DIV1     = 3'b001,
    SEL_DIV8     = 3'b010,
    SEL_DIV64    = 3'b011,
    SEL_DIV256   = 3'b100,
    SEL_DIV1024  = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } tick_sel_e;

  localparam int unsigned NUM_TAPS   = 4;
  localparam int unsigned PRESCALE_W = 10;
  localparam int unsigned SYNC_DEPTH = 2;

  // log2 of the divide ratio for each tap, in select-code order
  function automatic int unsigned tap_log2(int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import timer_tick_pkg::*;
#(
  parameter int unsigned CNT_W = PRESCALE_W,
  parameter int unsigned TAPS  = NUM_TAPS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam int unsigned LW = tap_log2(i);
    assign tap_o[i] = &cnt_q[LW-1:0];

    a_r4_tap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[i] |=> !tap_o[i]);
  end

  a_r5_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/tick_ext_edge.sv
module tick_ext_edge
  import timer_tick_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ext_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;

  a_r9_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r9_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  a_r8_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import timer_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_i,
  output logic       tick_o
);

  tick_sel_e           sel;
  logic [NUM_TAPS-1:0] tap;
  logic                ext_rise, ext_fall;
  logic                tick_d, tick_q;

  assign sel = tick_sel_e'(sel_i);

  tick_prescaler #(
    .CNT_W (PRESCALE_W),
    .TAPS  (NUM_TAPS)
  ) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap)
  );

  tick_ext_edge #(
    .STAGES (SYNC_DEPTH)
  ) u_ext_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  always_comb begin
    case (sel)
      SEL_OFF:      tick_d = 1'b0;
      SEL_DIV1:     tick_d = 1'b1;
      SEL_DIV8:     tick_d = tap[0];
      SEL_DIV64:    tick_d = tap[1];
      SEL_DIV256:   tick_d = tap[2];
      SEL_DIV1024:  tick_d = tap[3];
      SEL_EXT_FALL: tick_d = ext_fall;
      SEL_EXT_RISE: tick_d = ext_rise;
      default:      tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !tick_o);
  a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b000 |=> !tick_o);
  a_r3_div1_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b001 |=> tick_o);
  a_r6_rise_follows_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b111 && ext_rise) |=> tick_o);
  a_r7_fall_follows_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b110 && ext_fall) |=> tick_o);

endmodule

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       ext = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_ni) edges <= edges + 1;

  timer_tick_gen uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .ext_i  (ext),
    .tick_o (tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // tick must follow edges%n==0 for a window; returns first mismatch
  task automatic run_div(input string req, input logic [2:0] code, input int n, input int cycles);
    int bad = 0;
    int act = 0;
    int exp = 0;
    @(negedge clk) sel = code;
    @(negedge clk);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (int'(tick) != int'(edges % n == 0)) begin
        if (bad == 0) begin act = int'(tick); exp = int'(edges % n == 0); end
        bad++;
      end
    end
    if (bad != 0) check(req, act, exp);
    else check(req, 0, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(tick), 0);
    rst_ni = 1'b1;
    #1;
    check("R1 after release", int'(tick), 0);
  endtask

  task automatic test_off();
    int seen = 0;
    @(negedge clk) sel = 3'b000;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k % 3 == 0) ext = ~ext;
      seen += int'(tick);
    end
    check("R2 off ticks", seen, 0);
    ext = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_div1();
    int seen = 0;
    @(negedge clk) sel = 3'b001;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      seen += int'(tick);
    end
    check("R3 every cycle", seen, 20);
  endtask

  task automatic test_dividers();
    run_div("R4 div8",    3'b010, 8,    100);
    run_div("R4 div64",   3'b011, 64,   300);
    run_div("R4 div256",  3'b100, 256,  800);
    run_div("R4 div1024", 3'b101, 1024, 2100);
  endtask

  task automatic test_switch();
    @(negedge clk) sel = 3'b101;
    repeat (333) @(negedge clk);
    run_div("R5 phase after switch to div64", 3'b011, 64, 200);
    repeat (17) @(negedge clk);
    run_div("R5 phase after switch to div8",  3'b010, 8, 50);
  endtask

  // drive ext to lvl at a negedge; tick expected only at the third sample
  task automatic ext_step(input string req, input logic lvl, input int exp_at3);
    int pat = 0;
    @(negedge clk) ext = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (tick) pat |= (1 << k);
    end
    check(req, pat, exp_at3 ? (1 << 3) : 0);
  endtask

  task automatic test_ext_rise();
    @(negedge clk) begin sel = 3'b111; ext = 1'b0; end
    repeat (5) @(negedge clk);
    ext_step("R6 rising edge tick", 1'b1, 1);
    ext_step("R8 falling ignored in rise mode", 1'b0, 0);
  endtask

  task automatic test_ext_fall();
    @(negedge clk) begin sel = 3'b110; ext = 1'b0; end
    repeat (5) @(negedge clk);
    ext_step("R8 rising ignored in fall mode", 1'b1, 0);
    ext_step("R7 falling edge tick", 1'b0, 1);
  endtask

  task automatic test_toggle();
    int seen = 0;
    int runs = 0;
    logic last = 1'b0;
    @(negedge clk) begin sel = 3'b111; ext = 1'b0; end
    repeat (5) @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      if (k < 16 && k % 2 == 0) ext = ~ext;
      @(negedge clk);
      seen += int'(tick);
      if (tick && last) runs++;
      last = tick;
    end
    check("R9 tick count", seen, 4);
    check("R9 no merged pulses", runs, 0);
    ext = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_off();
    test_div1();
    test_dividers();
    test_switch();
    test_ext_rise();
    test_ext_fall();
    test_toggle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule